// File: doc/BRIEF.md
# MDIO Management Master

This block is a memory-mapped management master for the two-wire MDC/MDIO serial bus that configures Ethernet PHYs (Clause 22 frames). Software sets up a clock divider and an enable bit in a control register. It then writes a single command word that holds a launch flag, a direction flag, a 5-bit PHY address, a 5-bit PHY register number and 16 data bits. The block clocks the frame out on MDC/MDIO and clears the launch flag when the frame ends. For a read, it puts the returned data and an acknowledge flag back into the same command word.

The frame engine is a two-state machine. `FR_IDLE` waits for a launch. The transition `FR_IDLE -> FR_SHIFT` happens one cycle after an accepted command write. `FR_SHIFT` walks through 64 bit slots. The transition `FR_SHIFT -> FR_IDLE` happens on the MDC falling tick that ends bit slot 63. A divider counter makes the MDC waveform only while a frame is in flight.

Top module: `mdio_master`

## Requirements
- R1: After reset, the control word (address 0) reads 0x8000_0000, the command word (address 1) reads 0x0000_0000, and `mdc` and `mdio_oe` are low.
- R2: The control word keeps the divider in [15:0], enable in bit 30, fault in bit 19 and fault-enable in bit 18, all read/write. Bit 31 (not-ready) reads 1 while enable is clear and 0 while it is set. All other bits read 0.
- R3: A command write with bit 31 (GO) set, accepted while GO is clear and enable is set, starts a frame. GO reads 1 for exactly 64*(D+1)+1 cycles from the write edge, where D is the effective divider. GO then reads 0.
- R4: MDC has a period of D+1 bus clocks. It is low for floor((D+1)/2) clocks and then high for the rest. A programmed divider of 0 acts as 1. MDC stays low when no frame is in flight.
- R5: A write (bit 30 = 1) sends 32 ones, start 01, opcode 01, the PHY address [20:16], the register number [25:21], turnaround 10 and the data [15:0]. Every field goes MSB first and the master drives all 64 bits.
- R6: A read (bit 30 = 0) sends opcode 10 and releases MDIO (`mdio_oe` low) for bit slots 46 to 63. The 16 bits sampled in slots 48 to 63 land MSB first in command bits [15:0].
- R7: When a read ends, ACK (bit 29) is set if the PHY held slot 47 low and cleared otherwise. A write frame leaves ACK unchanged.
- R8: A command write that arrives while GO reads 1 is ignored as a whole. It starts no frame and changes no field.
- R9: A command write with GO set while enable is clear, or with GO clear, only stores the direction, address, register and data fields. It starts no frame and GO stays 0.
- R10: During a frame, `mdio_out` changes only at the edge where MDC falls. The PHY's MDIO is sampled at the edge where MDC rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Word address: 0 control, 1 command |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Serial data driven by the master |
| mdio_oe | output | 1 | Output enable for `mdio_out` |
| mdio_in | input | 1 | Serial data seen on the pin |

## Verification
The embedded assertions check the following on every cycle: GO covers the whole active frame, MDC stays quiet outside a frame, serial output changes only on MDC falls, the command fields stay frozen while GO is set, and ACK is held across write frames. Only the bench scenarios, with a behavioural PHY attached, can show the exact bit sequence of each frame, where the turnaround is released, the exact frame length and MDC duty for several dividers, and the ACK and data results of acknowledged and unacknowledged reads.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int CMD_GO    = 31;
    localparam int CMD_WR    = 30;
    localparam int CMD_ACK   = 29;
    localparam int CTL_NRDY  = 31;
    localparam int CTL_EN    = 30;
    localparam int CTL_FLT   = 19;
    localparam int CTL_FLTEN = 18;

    localparam int FLD_W      = 5;
    localparam int DAT_W      = 16;
    localparam int FRAME_BITS = 64;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int TA_SLOT    = 46;
    localparam int ACK_SLOT   = 47;
    localparam int DATA_SLOT  = 48;

    localparam logic [1:0] ADDR_CTL = 2'd0;
    localparam logic [1:0] ADDR_CMD = 2'd1;

    typedef enum logic [0:0] {
        FR_IDLE  = 1'b0,
        FR_SHIFT = 1'b1
    } frame_state_t;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] last;
    logic [DIV_W:0]   half;

    always_comb begin
        last      = (div == '0) ? DIV_W'(1) : div;
        half      = ({1'b0, last} + (DIV_W+1)'(1)) >> 1;
        rise_tick = run && ({1'b0, cnt} == half - (DIV_W+1)'(1));
        fall_tick = run && (cnt == last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else begin
            cnt <= fall_tick ? '0 : cnt + DIV_W'(1);
            if (rise_tick)      mdc <= 1'b1;
            else if (fall_tick) mdc <= 1'b0;
        end
    end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             wr_op,
    input  logic [FLD_W-1:0] phy_addr,
    input  logic [FLD_W-1:0] reg_num,
    input  logic [DAT_W-1:0] wr_data,
    input  logic             rise_tick,
    input  logic             fall_tick,
    input  logic             mdio_in,
    output logic             mdio_out,
    output logic             mdio_oe,
    output logic             busy,
    output logic             done,
    output logic             ack_seen,
    output logic [DAT_W-1:0] rd_data
);
    frame_state_t state, nxt;
    logic [IDX_W-1:0]      slot;
    logic [FRAME_BITS-1:0] shreg;
    logic                  op_wr;
    logic                  last_slot;

    assign last_slot = (slot == IDX_W'(FRAME_BITS-1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FR_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            FR_IDLE:  if (start) nxt = FR_SHIFT;
            FR_SHIFT: if (fall_tick && last_slot) nxt = FR_IDLE;
            default:  nxt = FR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot     <= '0;
            shreg    <= '1;
            op_wr    <= 1'b0;
            ack_seen <= 1'b0;
            rd_data  <= '0;
        end else if (state == FR_IDLE) begin
            if (start) begin
                slot  <= '0;
                op_wr <= wr_op;
                shreg <= {{32{1'b1}}, 2'b01, (wr_op ? 2'b01 : 2'b10),
                          phy_addr, reg_num, (wr_op ? 2'b10 : 2'b11),
                          (wr_op ? wr_data : {DAT_W{1'b1}})};
            end
        end else begin
            if (rise_tick) begin
                if (slot == IDX_W'(ACK_SLOT)) ack_seen <= !mdio_in;
                if (slot >= IDX_W'(DATA_SLOT)) rd_data <= {rd_data[DAT_W-2:0], mdio_in};
            end
            if (fall_tick && !last_slot) begin
                slot  <= slot + IDX_W'(1);
                shreg <= {shreg[FRAME_BITS-2:0], 1'b1};
            end
        end
    end

    always_comb begin
        busy     = (state == FR_SHIFT);
        done     = busy && fall_tick && last_slot;
        mdio_out = busy ? shreg[FRAME_BITS-1] : 1'b1;
        mdio_oe  = busy && (op_wr || (slot < IDX_W'(TA_SLOT)));
    end

    AST_READ_RELEASES_TA: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !op_wr && slot == IDX_W'(ACK_SLOT)) |-> !mdio_oe); // R6
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              done,
    input  logic              ack_in,
    input  logic [DAT_W-1:0]  rd_in,
    output logic [DIV_W-1:0]  div,
    output logic              start,
    output logic              go,
    output logic              wr_op,
    output logic [FLD_W-1:0]  phy_addr,
    output logic [FLD_W-1:0]  reg_num,
    output logic [DAT_W-1:0]  data
);
    logic en, flt, flt_en, ack;
    logic ctl_wr, cmd_wr, launch;

    assign ctl_wr = bus_we && (bus_addr == ADDR_W'(ADDR_CTL));
    assign cmd_wr = bus_we && (bus_addr == ADDR_W'(ADDR_CMD)) && !go;
    assign launch = cmd_wr && bus_wdata[CMD_GO] && en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div <= '0; en <= 1'b0; flt <= 1'b0; flt_en <= 1'b0;
        end else if (ctl_wr) begin
            div    <= bus_wdata[DIV_W-1:0];
            en     <= bus_wdata[CTL_EN];
            flt    <= bus_wdata[CTL_FLT];
            flt_en <= bus_wdata[CTL_FLTEN];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            go <= 1'b0; start <= 1'b0; wr_op <= 1'b0; ack <= 1'b0;
            phy_addr <= '0; reg_num <= '0; data <= '0;
        end else begin
            start <= launch;
            if (cmd_wr) begin
                wr_op    <= bus_wdata[CMD_WR];
                reg_num  <= bus_wdata[25:21];
                phy_addr <= bus_wdata[20:16];
                data     <= bus_wdata[DAT_W-1:0];
                go       <= launch;
            end else if (done) begin
                go <= 1'b0;
                if (!wr_op) begin
                    ack  <= ack_in;
                    data <= rd_in;
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(ADDR_CTL)) begin
            bus_rdata[CTL_NRDY]    = !en;
            bus_rdata[CTL_EN]      = en;
            bus_rdata[CTL_FLT]     = flt;
            bus_rdata[CTL_FLTEN]   = flt_en;
            bus_rdata[DIV_W-1:0]   = div;
        end else if (bus_addr == ADDR_W'(ADDR_CMD)) begin
            bus_rdata[CMD_GO]      = go;
            bus_rdata[CMD_WR]      = wr_op;
            bus_rdata[CMD_ACK]     = ack;
            bus_rdata[25:21]       = reg_num;
            bus_rdata[20:16]       = phy_addr;
            bus_rdata[DAT_W-1:0]   = data;
        end
    end

    AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (go && $past(go)) |-> ($stable(wr_op) && $stable(phy_addr) && $stable(reg_num))); // R8
    AST_WRITE_KEEPS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (done && wr_op) |=> $stable(ack)); // R7
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    input  logic              mdio_in
);
    logic [DIV_W-1:0] div;
    logic             start, go, wr_op, busy, done, ack_seen, rise_tick, fall_tick;
    logic [FLD_W-1:0] phy_addr, reg_num;
    logic [DAT_W-1:0] data, rd_data;

    mdio_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done(done),
        .ack_in(ack_seen), .rd_in(rd_data), .div(div), .start(start), .go(go),
        .wr_op(wr_op), .phy_addr(phy_addr), .reg_num(reg_num), .data(data)
    );

    mdio_clk_gen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(busy), .div(div), .mdc(mdc),
        .rise_tick(rise_tick), .fall_tick(fall_tick)
    );

    mdio_frame_engine u_frame (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_op(wr_op),
        .phy_addr(phy_addr), .reg_num(reg_num), .wr_data(data),
        .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_in(mdio_in),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .busy(busy), .done(done),
        .ack_seen(ack_seen), .rd_data(rd_data)
    );

    AST_GO_COVERS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> go); // R3
    AST_GO_ENDS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(go) |-> $past(done)); // R3
    AST_MDC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc); // R4
    AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$stable(mdio_out)) |-> $fell(mdc)); // R10
endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_out, mdio_oe;
    logic        mdio_in = 1'b1;

    int errors = 0;
    int checks = 0;

    // behavioural PHY
    logic        phy_ack = 1'b0;
    logic [15:0] phy_data = '0;
    logic        prev_mdc = 1'b0;
    int          bitn = 0, rises = 0, highs = 0;
    logic [63:0] cap_out = '0, cap_oe = '0;

    always #2 clk = ~clk;

    mdio_master u_mdio_master (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    always @(negedge clk) begin
        if (mdc) highs++;
        if (mdc && !prev_mdc) begin
            if (bitn < 64) begin
                cap_out[63-bitn] = mdio_out;
                cap_oe[63-bitn]  = mdio_oe;
            end
            bitn++;
            rises++;
        end
        if (!mdc && prev_mdc) begin
            if (bitn == 47)                   mdio_in = !phy_ack;
            else if (bitn >= 48 && bitn < 64) mdio_in = phy_data[63-bitn];
            else                              mdio_in = 1'b1;
        end
        prev_mdc = mdc;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic clear_phy();
        bitn = 0; rises = 0; highs = 0; cap_out = '0; cap_oe = '0; mdio_in = 1'b1;
    endtask

    // launch a command and count cycles with GO set
    task automatic run_cmd(input logic [31:0] cmd, output int go_cycles);
        logic [31:0] r;
        clear_phy();
        bus_write(2'd1, cmd);
        go_cycles = 0;
        bus_read(2'd1, r);
        while (r[31] && go_cycles < 5000) begin
            go_cycles++;
            @(negedge clk);
            bus_read(2'd1, r);
        end
    endtask

    task automatic t_reset();
        logic [31:0] r;
        bus_read(2'd0, r); chk("R1 ctl reset", r, 32'h8000_0000);
        bus_read(2'd1, r); chk("R1 cmd reset", r, 32'h0);
        chk("R1 mdc low", mdc, 0);
        chk("R1 oe low", mdio_oe, 0);
    endtask

    task automatic t_control();
        logic [31:0] r;
        bus_write(2'd0, 32'hFFF3_0003 & 32'h400C_FFFF | 32'h400C_0003);
        bus_read(2'd0, r); chk("R2 ctl readback", r, 32'h400C_FFFF & 32'h400C_0003 | (32'hFFF3_0003 & 32'h0000_FFFF));
        bus_write(2'd0, 32'hBFF3_0003);
        bus_read(2'd0, r); chk("R2 disabled fields", r, 32'h8000_0003);
        bus_write(2'd0, 32'h400C_0003);
        bus_read(2'd0, r); chk("R2 enabled ctl", r, 32'h400C_0003);
    endtask

    task automatic t_read_ack();
        logic [31:0] r; int n;
        phy_ack = 1'b1; phy_data = 16'h3C5A;
        run_cmd(32'h8023_0000, n);
        chk("R3 go cycles D=3", n, 257);
        chk("R4 high clocks D=3", highs, 128);
        chk("R4 mdc periods", rises, 64);
        chk("R6 read header", cap_out[63:18],
            {32'hFFFF_FFFF, 2'b01, 2'b10, 5'd3, 5'd1});
        chk("R6 release mask", cap_oe, {{46{1'b1}}, 18'h0});
        bus_read(2'd1, r); chk("R7 read ack data", r, 32'h2023_3C5A);
    endtask

    task automatic t_write();
        logic [31:0] r; int n;
        run_cmd(32'hC0B1_A5C3, n);
        chk("R5 write frame", cap_out,
            {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h11, 5'h05, 2'b10, 16'hA5C3});
        chk("R5 write fully driven", cap_oe, 64'hFFFF_FFFF_FFFF_FFFF);
        bus_read(2'd1, r); chk("R7 write keeps ack", r, 32'h60B1_A5C3);
    endtask

    task automatic t_read_nack();
        logic [31:0] r; int n;
        phy_ack = 1'b0; phy_data = 16'h0F0F;
        run_cmd(32'h8023_0000, n);
        bus_read(2'd1, r); chk("R7 no ack", r, 32'h0023_0F0F);
    endtask

    task automatic t_dividers();
        int n;
        bus_write(2'd0, 32'h4000_0006);
        run_cmd(32'hC000_0000, n);
        chk("R3 go cycles D=6", n, 449);
        chk("R4 high clocks D=6", highs, 256);
        bus_write(2'd0, 32'h4000_0000);
        run_cmd(32'hC000_0000, n);
        chk("R4 divider zero as one", n, 129);
        chk("R4 high clocks D=0", highs, 64);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] r; int n;
        bus_write(2'd0, 32'h4000_0003);
        phy_ack = 1'b1; phy_data = 16'h55AA;
        clear_phy();
        bus_write(2'd1, 32'h80E9_0000);
        repeat (20) @(negedge clk);
        bus_write(2'd1, 32'hC000_1234);
        n = 0;
        bus_read(2'd1, r);
        while (r[31] && n < 5000) begin n++; @(negedge clk); bus_read(2'd1, r); end
        repeat (40) @(negedge clk);
        chk("R8 single frame", rises, 64);
        bus_read(2'd1, r); chk("R8 fields kept", r, 32'h20E9_55AA);
    endtask

    task automatic t_no_launch();
        logic [31:0] r;
        bus_write(2'd0, 32'h0000_0003);
        bus_read(2'd0, r); chk("R2 not ready", r, 32'h8000_0003);
        clear_phy();
        bus_write(2'd1, 32'hC044_BEEF);
        bus_read(2'd1, r); chk("R9 disabled go", r, 32'h6044_BEEF);
        repeat (60) @(negedge clk);
        chk("R9 no frame disabled", rises, 0);
        bus_write(2'd0, 32'h4000_0003);
        bus_write(2'd1, 32'h0062_0001);
        bus_read(2'd1, r); chk("R9 go clear store", r, 32'h2062_0001);
        repeat (60) @(negedge clk);
        chk("R9 no frame go clear", rises, 0);
        chk("R4 mdc idle low", mdc, 0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_control();
        t_read_ack();
        t_write();
        t_read_nack();
        t_dividers();
        t_busy_ignore();
        t_no_launch();
        finish_run();
    end
endmodule